// File: doc/BRIEF.md
# Serial Management Slave with Register Bank

This block is the device side of a two-wire serial management link. A management master supplies a clock and a bidirectional data line. The slave watches the line for a preamble of ones and a start pattern. It then decodes the opcode, the device address and the register address. On a read it turns the line around and shifts a 16-bit register out. On a write it takes in 16 data bits and raises a one-cycle write strobe with the address and data. A small register bank is built in. It holds a read/write control register, a read-only status register and a read-only self-status register that reports the device address.

The device address comes from strap inputs. These are captured while reset is held low, so the management clock must run during reset. A frame is answered when its device address is all zeros (broadcast) or equals the captured strap value. Any other frame is followed to its end without driving the line, raising a strobe or changing a register. After every frame, answered or not, the slave needs a fresh preamble before it will accept the next one.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: After reset, `mdio_oe` and `wr_stb` are 0, and register 0x00 reads back as the control reset value 16'h3100.
- R2: A frame is accepted only when at least 32 consecutive 1 bits come before the start pattern 0 then 1. With 31 ones, the frame has no effect. With 40 ones, it is served.
- R3: If 32 or more ones are followed by 0 then 0 instead of 0 then 1, the slave returns to idle and the rest of that frame has no effect.
- R4: A read frame has opcode bits 1 then 0. The slave leaves the line released for the first turnaround bit and drives 0 for the second. It drives the data field and releases the line on the edge that samples the last frame bit.
- R5: Read data is the addressed 16-bit register, most significant bit first. The status register 0x01 reads 16'h7809, and any address other than 0x00, 0x01 and 0x19 reads 16'h0000.
- R6: A write frame has opcode bits 0 then 1. After the edge that samples the last data bit, `wr_stb` is high for exactly one cycle, with `wr_addr` set to the frame's register address and `wr_data` set to its 16 data bits. `mdio_oe` stays 0 for the whole write frame.
- R7: The 5-bit device address and the 5-bit register address are both sent most significant bit first. A frame is served when its device address is 00000 or equals the captured strap value. Any other address gives no line drive and no strobe.
- R8: A write to 0x00 changes what 0x00 reads back. A write to 0x01 or to 0x19 leaves what those registers read back unchanged.
- R9: Register 0x19 reads {11'b0, strap}, where strap is the value present while reset was low. A change on `strap_phyad` after reset changes neither the reported address nor which frames are served.
- R10: A frame with opcode 00 or 11 gives no line drive and no strobe, and does not change register 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; the strap is captured while it is low |
| strap_phyad | input | 5 | Device address strap |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdio_o | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| wr_stb | output | 1 | One-cycle strobe for a completed write frame |
| wr_addr | output | 5 | Register address of the completed write |
| wr_data | output | 16 | Data of the completed write |

## Verification
Reads and writes are sent with both the broadcast address and the strapped address. Reads of one register before and after a write show whether the write reached the bank. Reads of the status, self-status and unimplemented addresses separate the read-only paths from the read/write path, and a read after a write to each read-only address shows that the write was blocked. Frames are also sent with a foreign address, the address a strap changed after reset would select, a 31-bit preamble, a 0-0 start and the two invalid opcodes. Each of these is compared bit by bit with the line and strobe expected from the requirements, which tells apart a frame that is wrongly accepted from one that is correctly ignored.

// File: rtl/mdio_pkg.sv
// Shared constants for the serial management slave.
// Assumes: 5-bit device and register addresses and 16-bit registers.
package mdio_pkg;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 16;
    localparam int OP_W    = 2;
    localparam int PRE_LEN = 32;

    localparam logic [OP_W-1:0] OP_READ  = 2'b10;
    localparam logic [OP_W-1:0] OP_WRITE = 2'b01;

    localparam logic [ADDR_W-1:0] REG_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] REG_STAT = 5'h01;
    localparam logic [ADDR_W-1:0] REG_SELF = 5'h19;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_FRAME = 2'd2
    } rx_state_t;
endpackage

// File: rtl/mdio_regfile.sv
// Register bank: control (read/write), status (fixed) and self-status
// (reports the strapped address in bits [ADDR_W-1:0]).
// Assumes: one write strobe per completed write frame. Writes to
// read-only addresses are dropped. The strap is sampled only while rst_n is low.
module mdio_regfile
    import mdio_pkg::*;
#(
    parameter logic [DATA_W-1:0] CTRL_RST = 16'h3100,
    parameter logic [DATA_W-1:0] STAT_VAL = 16'h7809
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] strap_phyad,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] phyad
);
    localparam int PAD_W = DATA_W - ADDR_W;

    logic [DATA_W-1:0] ctrl_q;
    logic [ADDR_W-1:0] phyad_q;

    // Control register: reset value, then updated only by writes to its address.
    always_ff @(posedge mdc) begin
        if (!rst_n)
            ctrl_q <= CTRL_RST;
        else if (wr_stb && (wr_addr == REG_CTRL))
            ctrl_q <= wr_data;
    end

    // Strap capture: follows the pins during reset, frozen afterwards.
    always_ff @(posedge mdc) begin
        if (!rst_n)
            phyad_q <= strap_phyad;
    end

    // Read mux: unimplemented addresses return zero.
    always_comb begin
        case (rd_addr)
            REG_CTRL: rd_data = ctrl_q;
            REG_STAT: rd_data = STAT_VAL;
            REG_SELF: rd_data = {{PAD_W{1'b0}}, phyad_q};
            default:  rd_data = '0;
        endcase
    end

    assign phyad = phyad_q;

    a_r8_ro_write_keeps_ctrl: assert property (@(posedge mdc) disable iff (!rst_n)
        (wr_stb && (wr_addr != REG_CTRL)) |=> $stable(ctrl_q));

    a_r9_strap_frozen: assert property (@(posedge mdc) disable iff (!rst_n)
        $past(rst_n) |-> $stable(phyad_q));
endmodule

// File: rtl/mdio_frame_rx.sv
// Frame receiver: finds the preamble and start pattern, follows the frame
// bit positions, latches opcode, address match and register address,
// and issues the write strobe after the last data bit.
// Assumes: mdio_i is sampled on the rising edge of mdc. Every frame,
// whether served or not, is followed to its last bit.
module mdio_frame_rx
    import mdio_pkg::*;
#(
    parameter int PRE_ONES = PRE_LEN
) (
    input  logic                 mdc,
    input  logic                 rst_n,
    input  logic                 mdio_i,
    input  logic [ADDR_W-1:0]    phyad,
    output logic                 frm_act,
    output logic [4:0]           frm_pos,
    output logic                 rd_sel,
    output logic [ADDR_W-1:0]    reg_addr,
    output logic                 wr_stb,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [DATA_W-1:0]    wr_data
);
    localparam int ONE_W      = $clog2(PRE_ONES + 1);
    localparam int POS_PHY    = OP_W + ADDR_W - 1;
    localparam int POS_REG    = POS_PHY + ADDR_W;
    localparam int POS_LASTI  = POS_REG + 2 + DATA_W;
    localparam logic [4:0] P_OP   = 5'(OP_W - 1);
    localparam logic [4:0] P_PHY  = 5'(POS_PHY);
    localparam logic [4:0] P_REG  = 5'(POS_REG);
    localparam logic [4:0] P_LAST = 5'(POS_LASTI);
    localparam logic [ONE_W-1:0] ONES_FULL = ONE_W'(PRE_ONES);

    rx_state_t         state;
    logic [ONE_W-1:0]  ones;
    logic [4:0]        pos;
    logic [DATA_W-1:0] sh;
    logic [OP_W-1:0]   op_q;
    logic              match_q;
    logic [ADDR_W-1:0] regad_q;
    logic [ADDR_W-1:0] rx_addr;
    logic              frm_last;

    assign rx_addr  = {sh[ADDR_W-2:0], mdio_i};
    assign frm_last = (state == RX_FRAME) && (pos == P_LAST);

    // Sequencer: preamble count, start check, frame position counter.
    always_ff @(posedge mdc) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            ones  <= '0;
            pos   <= '0;
        end else begin
            case (state)
                RX_IDLE: begin
                    if (mdio_i) begin
                        if (ones != ONES_FULL) ones <= ones + 1'b1;
                    end else if (ones == ONES_FULL) begin
                        state <= RX_START;
                    end else begin
                        ones <= '0;
                    end
                end
                RX_START: begin
                    ones  <= '0;
                    pos   <= '0;
                    state <= mdio_i ? RX_FRAME : RX_IDLE;
                end
                default: begin
                    if (frm_last) state <= RX_IDLE;
                    pos <= pos + 1'b1;
                end
            endcase
        end
    end

    // Field capture: serial shift plus opcode, match and register address.
    always_ff @(posedge mdc) begin
        if (!rst_n) begin
            sh      <= '0;
            op_q    <= '0;
            match_q <= 1'b0;
            regad_q <= '0;
        end else if (state == RX_START) begin
            sh      <= '0;
            op_q    <= '0;
            match_q <= 1'b0;
        end else if (state == RX_FRAME) begin
            sh <= {sh[DATA_W-2:0], mdio_i};
            if (pos == P_OP)  op_q    <= {sh[0], mdio_i};
            if (pos == P_PHY) match_q <= (rx_addr == '0) || (rx_addr == phyad);
            if (pos == P_REG) regad_q <= rx_addr;
        end
    end

    // Write strobe: one cycle after the last data bit of a served write.
    always_ff @(posedge mdc) begin
        if (!rst_n) begin
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= frm_last && match_q && (op_q == OP_WRITE);
            if (frm_last && match_q && (op_q == OP_WRITE)) begin
                wr_addr <= regad_q;
                wr_data <= {sh[DATA_W-2:0], mdio_i};
            end
        end
    end

    assign frm_act  = (state == RX_FRAME);
    assign frm_pos  = pos;
    assign rd_sel   = match_q && (op_q == OP_READ);
    assign reg_addr = regad_q;

    a_r6_strobe_single: assert property (@(posedge mdc) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    a_r2_start_after_preamble: assert property (@(posedge mdc) disable iff (!rst_n)
        (state == RX_START) |-> $past(mdio_i) == 1'b0);
endmodule

// File: rtl/mdio_rd_drv.sv
// Read driver: releases the line for the first turnaround bit, drives 0
// for the second, shifts the register out MSB first, then releases.
// Assumes: frm_pos counts frame bits after the start pattern, from 0.
module mdio_rd_drv
    import mdio_pkg::*;
(
    input  logic              mdc,
    input  logic              rst_n,
    input  logic              frm_act,
    input  logic [4:0]        frm_pos,
    input  logic              rd_sel,
    input  logic [DATA_W-1:0] rd_data,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int POS_TA1I = OP_W + 2 * ADDR_W;
    localparam logic [4:0] P_TA1  = 5'(POS_TA1I);
    localparam logic [4:0] P_LAST = 5'(POS_TA1I + 1 + DATA_W);

    logic [DATA_W-1:0] out_sh;

    // Output sequencing per frame position while a served read is under way.
    always_ff @(posedge mdc) begin
        if (!rst_n) begin
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
            out_sh  <= '0;
        end else if (frm_act && rd_sel && (frm_pos == P_TA1)) begin
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b1;
            out_sh  <= rd_data;
        end else if (frm_act && rd_sel && (frm_pos > P_TA1) && (frm_pos < P_LAST)) begin
            mdio_o  <= out_sh[DATA_W-1];
            mdio_oe <= 1'b1;
            out_sh  <= {out_sh[DATA_W-2:0], 1'b0};
        end else begin
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
        end
    end

    a_r4_turnaround_zero: assert property (@(posedge mdc) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_o);

    a_r4_drive_in_frame: assert property (@(posedge mdc) disable iff (!rst_n)
        mdio_oe |-> $past(frm_act));
endmodule

// File: rtl/mdio_mgmt_slave.sv
// Top: serial management slave with its register bank.
// Assumes: mdc runs during reset, so the strap and the synchronous reset
// take effect. The pad combines mdio_o and mdio_oe with a pull-up.
module mdio_mgmt_slave
    import mdio_pkg::*;
(
    input  logic              mdc,
    input  logic              rst_n,
    input  logic [4:0]        strap_phyad,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              wr_stb,
    output logic [4:0]        wr_addr,
    output logic [15:0]       wr_data
);
    logic              frm_act;
    logic [4:0]        frm_pos;
    logic              rd_sel;
    logic [ADDR_W-1:0] reg_addr;
    logic [DATA_W-1:0] rd_data;
    logic [ADDR_W-1:0] phyad;

    mdio_regfile u_regs (
        .mdc         (mdc),
        .rst_n       (rst_n),
        .strap_phyad (strap_phyad),
        .wr_stb      (wr_stb),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (reg_addr),
        .rd_data     (rd_data),
        .phyad       (phyad)
    );

    mdio_frame_rx u_rx (
        .mdc      (mdc),
        .rst_n    (rst_n),
        .mdio_i   (mdio_i),
        .phyad    (phyad),
        .frm_act  (frm_act),
        .frm_pos  (frm_pos),
        .rd_sel   (rd_sel),
        .reg_addr (reg_addr),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    mdio_rd_drv u_drv (
        .mdc     (mdc),
        .rst_n   (rst_n),
        .frm_act (frm_act),
        .frm_pos (frm_pos),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

    a_r6_no_drive_on_write: assert property (@(posedge mdc) disable iff (!rst_n)
        wr_stb |-> (!mdio_oe && !$past(mdio_oe)));
endmodule

// File: tb/mdio_mgmt_slave_bench.sv
// Bench: a behavioural reference predicts line drive and strobe after
// every sampled bit and compares them on every clock.
module mdio_mgmt_slave_bench;
    logic        mdc = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  strap_phyad = 5'h05;
    logic        mdio_i = 1'b1;
    logic        mdio_o, mdio_oe, wr_stb;
    logic [4:0]  wr_addr;
    logic [15:0] wr_data;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] ref_ctrl = 16'h3100;
    logic [4:0]  ref_strap = 5'h05;
    localparam logic [15:0] STAT_EXP = 16'h7809;

    logic        p_valid = 1'b0;
    logic        p_oe, p_o, p_stb;
    logic [4:0]  p_addr;
    logic [15:0] p_data;
    string       p_req;

    always #4 mdc = ~mdc;

    mdio_mgmt_slave u_mdio_mgmt_slave (
        .mdc(mdc), .rst_n(rst_n), .strap_phyad(strap_phyad), .mdio_i(mdio_i),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    task automatic check_pending();
        bit ok;
        if (p_valid) begin
            n_chk++;
            ok = (mdio_oe == p_oe) && (wr_stb == p_stb)
                 && (!p_oe || (mdio_o == p_o))
                 && (!p_stb || ((wr_addr == p_addr) && (wr_data == p_data)));
            if (!ok) begin
                n_fail++;
                $display("FAIL %s: oe=%b o=%b stb=%b addr=%h data=%h expected oe=%b o=%b stb=%b addr=%h data=%h",
                         p_req, mdio_oe, mdio_o, wr_stb, wr_addr, wr_data,
                         p_oe, p_o, p_stb, p_addr, p_data);
            end
        end
    endtask

    // One bit time: check the previous prediction, drive a bit, store the next prediction.
    task automatic step(input logic b, input logic eoe, input logic eo, input logic estb,
                        input logic [4:0] ea, input logic [15:0] ed, input string req);
        @(negedge mdc);
        check_pending();
        mdio_i  = mdio_oe ? mdio_o : b;
        p_valid = 1'b1;
        p_oe = eoe; p_o = eo; p_stb = estb; p_addr = ea; p_data = ed; p_req = req;
    endtask

    function automatic logic [15:0] ref_read(input logic [4:0] a);
        case (a)
            5'h00:   return ref_ctrl;
            5'h01:   return STAT_EXP;
            5'h19:   return {11'b0, ref_strap};
            default: return 16'h0000;
        endcase
    endfunction

    task automatic frame(input int npre, input logic [1:0] st, input logic [1:0] op,
                         input logic [4:0] phy, input logic [4:0] ra,
                         input logic [15:0] data, input string req);
        bit valid, match, rd, wr, isrd;
        logic [15:0] rv;
        logic b;
        valid = (npre >= 32) && (st == 2'b01);
        match = (phy == 5'h00) || (phy == ref_strap);
        isrd  = (op == 2'b10);
        rd    = valid && match && isrd;
        wr    = valid && match && (op == 2'b01);
        rv    = ref_read(ra);
        step(1'b0, 0, 0, 0, '0, '0, req);
        for (int i = 0; i < npre; i++) step(1'b1, 0, 0, 0, '0, '0, req);
        step(st[1], 0, 0, 0, '0, '0, req);
        step(st[0], 0, 0, 0, '0, '0, req);
        for (int p = 0; p < 30; p++) begin
            if (p < 2)       b = op[1-p];
            else if (p < 7)  b = phy[6-p];
            else if (p < 12) b = ra[11-p];
            else if (p < 14) b = isrd ? 1'b1 : (p == 12);
            else             b = isrd ? 1'b1 : data[29-p];
            step(b, rd && (p >= 12) && (p <= 28),
                 (p >= 13 && p <= 28) ? rv[28-p] : 1'b0,
                 wr && (p == 29), ra, data, req);
        end
        if (wr && ra == 5'h00) ref_ctrl = data;
    endtask

    initial begin
        repeat (4) @(negedge mdc);
        rst_n = 1'b1;
        step(1'b1, 0, 0, 0, '0, '0, "R1 reset outputs idle");
        strap_phyad = 5'h0A;
        frame(32, 2'b01, 2'b10, 5'h05, 5'h00, 16'h0, "R1 R4 R5 reset ctrl read");
        frame(32, 2'b01, 2'b01, 5'h00, 5'h00, 16'hA5C3, "R6 R7 broadcast write");
        frame(32, 2'b01, 2'b10, 5'h05, 5'h00, 16'h0, "R5 R8 ctrl readback");
        frame(32, 2'b01, 2'b01, 5'h05, 5'h01, 16'hFFFF, "R6 R8 write to status");
        frame(32, 2'b01, 2'b10, 5'h00, 5'h01, 16'h0, "R5 R8 status unchanged");
        frame(32, 2'b01, 2'b01, 5'h05, 5'h19, 16'h001F, "R8 write to self-status");
        frame(32, 2'b01, 2'b10, 5'h05, 5'h19, 16'h0, "R8 R9 self-status strap");
        frame(32, 2'b01, 2'b10, 5'h05, 5'h07, 16'h0, "R5 unimplemented reads zero");
        frame(32, 2'b01, 2'b10, 5'h0A, 5'h00, 16'h0, "R7 R9 later strap not served");
        frame(32, 2'b01, 2'b01, 5'h0A, 5'h00, 16'h1234, "R7 foreign write ignored");
        frame(32, 2'b01, 2'b01, 5'h13, 5'h00, 16'h1234, "R7 foreign write ignored");
        frame(31, 2'b01, 2'b01, 5'h05, 5'h00, 16'h5555, "R2 short preamble ignored");
        frame(32, 2'b00, 2'b01, 5'h05, 5'h00, 16'h6666, "R3 bad start ignored");
        frame(32, 2'b01, 2'b11, 5'h05, 5'h00, 16'h7777, "R10 opcode 11 ignored");
        frame(32, 2'b01, 2'b00, 5'h00, 5'h00, 16'h8888, "R10 opcode 00 ignored");
        frame(40, 2'b01, 2'b10, 5'h05, 5'h00, 16'h0, "R2 R8 R10 long preamble read");
        frame(32, 2'b01, 2'b01, 5'h05, 5'h00, 16'h0F0F, "R6 strapped write");
        frame(32, 2'b01, 2'b10, 5'h00, 5'h00, 16'h0, "R5 readback after write");
        step(1'b1, 0, 0, 0, '0, '0, "R4 release after read");
        step(1'b1, 0, 0, 0, '0, '0, "R4 idle");
        @(negedge mdc);
        check_pending();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge mdc);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule